// File: doc/BRIEF.md
# Dual-Rate Serial Baud Tick Generator

This block turns the bus clock into two independent rate enables for a serial port: one paces the transmitter, the other the receiver. An 8-bit rate register holds three selects. The top two bits choose a shared first-stage prescaler with the factors 1, 3, 4 or 13. Two 3-bit fields each choose a power-of-two divisor from 1 to 128, one field for transmit and one for receive. Each direction also has an 8-bit fine divisor input. When that input is nonzero, it replaces the coarse divisor of that direction only.

Each direction's period in bus clocks is the prescaler factor times its effective divisor. A per-direction counter produces a one-cycle tick at the end of every period. Any write to the rate register, and any change on either fine input, sends both counters back to zero. The new period therefore starts cleanly from that clock edge. Software reads the register back through a plain read-data output.

Top module: `sci_rate_gen`

## Requirements
- R1: The rate register is laid out as prescaler select in bits 7:6, transmit divisor select in bits 5:3 and receive divisor select in bits 2:0. A write takes effect at the clock edge where rate_wr is high. rate_rdata then returns the last written byte and holds it until the next write.
- R2: After reset, rate_rdata reads 00h. With both fine inputs at zero, each tick is high on every cycle from the first edge after reset onward.
- R3: Prescaler select 00 gives factor 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R4: A coarse divisor select of value k (0 to 7) gives the factor 2 to the power k, so 000 gives 1 and 111 gives 128.
- R5: tx_tick repeats every P*T bus clocks and rx_tick every P*R bus clocks. P is the prescaler factor and T, R are the effective divisors. A tick never lasts more than one cycle when its period exceeds one.
- R6: A fine input of 00h leaves the coarse divisor of its direction in use. A nonzero fine value V makes that direction's effective divisor V, so a period of up to 13*255 = 3315 clocks is possible.
- R7: The transmit fine input has no effect on the receive period, and the receive fine input has no effect on the transmit period.
- R8: A write to the rate register (even of the same value) or a change on either fine input at clock edge E clears both counters. Neither tick is high in the cycle after E. Each direction's first tick then follows at edge E+N, where N is its new period.
- R9: When a direction's total division is 1, its tick is high on every cycle except the cycle directly after a restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| rate_wr | input | 1 | Write strobe for the rate register |
| rate_wdata | input | 8 | Byte written to the rate register |
| rate_rdata | output | 8 | Current contents of the rate register |
| tx_fine | input | FINE_W (8) | Transmit fine divisor, 0 selects the coarse divisor |
| rx_fine | input | FINE_W (8) | Receive fine divisor, 0 selects the coarse divisor |
| tx_tick | output | 1 | One-cycle transmit rate enable |
| rx_tick | output | 1 | One-cycle receive rate enable |

## Verification
The properties assume that the fine inputs and the write port change only between clock edges. They treat every such change as a restart, so they never have to reason about a period that changes while a count is in flight. The stimulus drives all inputs a fixed delay after the rising edge. It holds each configuration long enough for several complete periods, capped for the longest divisions, before moving to the next. Randomized register values and fine values, about half of them zero, are mixed with directed cases. Those cases cover unity division, the 1664 and 3315 clock extremes, one-sided fine overrides, and restarts issued partway through a period.

// File: rtl/sci_rate_pkg.sv
`timescale 1ns/1ps
package sci_rate_pkg;

   // First-stage factor chosen by the two-bit prescaler select.
   function automatic int unsigned presc_factor(input logic [1:0] psel);
      case (psel)
         2'd0:    return 1;
         2'd1:    return 3;
         2'd2:    return 4;
         default: return 13;
      endcase
   endfunction

   // Total bus clocks per tick for one direction.
   function automatic int unsigned div_total(input logic [1:0] psel,
                                             input int unsigned csel,
                                             input int unsigned fine);
      int unsigned d;
      d = (fine != 0) ? fine : (32'd1 << csel);
      return presc_factor(psel) * d;
   endfunction

endpackage

// File: rtl/sci_rate_reg.sv
`timescale 1ns/1ps
module sci_rate_reg #(
   parameter int REG_W  = 8,
   parameter int FINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_wr,
   input  logic [REG_W-1:0]  rate_wdata,
   input  logic [FINE_W-1:0] tx_fine,
   input  logic [FINE_W-1:0] rx_fine,
   output logic [REG_W-1:0]  rate_q,
   output logic              restart
);

   logic [FINE_W-1:0] tx_fine_q;
   logic [FINE_W-1:0] rx_fine_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q    <= '0;
         tx_fine_q <= '0;
         rx_fine_q <= '0;
      end else begin
         if (rate_wr) rate_q <= rate_wdata;
         tx_fine_q <= tx_fine;
         rx_fine_q <= rx_fine;
      end
   end

   // Any write, or a fresh value on a fine input, realigns both counters.
   always_comb begin
      restart = rate_wr | (tx_fine != tx_fine_q) | (rx_fine != rx_fine_q);
   end

endmodule

// File: rtl/sci_rate_div.sv
`timescale 1ns/1ps
module sci_rate_div #(
   parameter int FINE_W = 8,
   parameter int CSEL_W = 3,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [1:0]        psel,
   input  logic [CSEL_W-1:0] csel,
   input  logic [FINE_W-1:0] fine,
   output logic              tick
);

   int unsigned       total;
   logic [CNT_W-1:0]  last_cnt;
   logic [CNT_W-1:0]  cnt;

   always_comb begin
      total    = sci_rate_pkg::div_total(psel, 32'(csel), 32'(fine));
      last_cnt = CNT_W'(total - 32'd1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (restart) begin
         cnt  <= '0;
         tick <= 1'b0;
      end else if (cnt == last_cnt) begin
         cnt  <= '0;
         tick <= 1'b1;
      end else begin
         cnt  <= cnt + 1'b1;
         tick <= 1'b0;
      end
   end

endmodule

// File: rtl/sci_rate_gen.sv
`timescale 1ns/1ps
module sci_rate_gen #(
   parameter int FINE_W = 8,
   parameter int CSEL_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rate_wr,
   input  logic [7:0]        rate_wdata,
   output logic [7:0]        rate_rdata,
   input  logic [FINE_W-1:0] tx_fine,
   input  logic [FINE_W-1:0] rx_fine,
   output logic              tx_tick,
   output logic              rx_tick
);

   localparam int REG_W      = 2 + 2 * CSEL_W;
   localparam int MAX_COARSE = 1 << ((1 << CSEL_W) - 1);
   localparam int MAX_FINE   = (1 << FINE_W) - 1;
   localparam int MAX_DIV    = (MAX_COARSE > MAX_FINE) ? MAX_COARSE : MAX_FINE;
   localparam int CNT_W      = $clog2(13 * MAX_DIV + 1);

   if (REG_W != 8) begin : g_bad_layout
      $error("sci_rate_gen: select fields must fill an 8-bit register");
   end
   if (FINE_W < 1 || FINE_W > 16) begin : g_bad_fine
      $error("sci_rate_gen: FINE_W out of range");
   end

   logic [REG_W-1:0]  rate_q;
   logic              restart;
   logic [1:0]        ticks;

   sci_rate_reg #(.REG_W(REG_W), .FINE_W(FINE_W)) u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .rate_wr    (rate_wr),
      .rate_wdata (rate_wdata),
      .tx_fine    (tx_fine),
      .rx_fine    (rx_fine),
      .rate_q     (rate_q),
      .restart    (restart)
   );

   for (genvar gi = 0; gi < 2; gi++) begin : g_dir
      logic [CSEL_W-1:0] sel;
      logic [FINE_W-1:0] fine;
      if (gi == 0) begin : g_tx
         assign sel  = rate_q[2*CSEL_W-1 -: CSEL_W];
         assign fine = tx_fine;
      end else begin : g_rx
         assign sel  = rate_q[CSEL_W-1:0];
         assign fine = rx_fine;
      end
      sci_rate_div #(.FINE_W(FINE_W), .CSEL_W(CSEL_W), .CNT_W(CNT_W)) u_div (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .psel    (rate_q[REG_W-1 -: 2]),
         .csel    (sel),
         .fine    (fine),
         .tick    (ticks[gi])
      );
   end

   assign rate_rdata = rate_q;
   assign tx_tick    = ticks[0];
   assign rx_tick    = ticks[1];

endmodule

// File: rtl/sci_rate_chk.sv
`timescale 1ns/1ps
module sci_rate_chk #(
   parameter int FINE_W = 8,
   parameter int CSEL_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rate_wr,
   input logic [7:0]        rate_wdata,
   input logic [7:0]        rate_rdata,
   input logic [FINE_W-1:0] tx_fine,
   input logic [FINE_W-1:0] rx_fine,
   input logic              tx_tick,
   input logic              rx_tick
);

   int unsigned       tot_tx, tot_rx;
   int unsigned       prev_tx, prev_rx;
   logic              rs_seen;
   logic [FINE_W-1:0] txf_d, rxf_d;

   always_comb begin
      tot_tx = sci_rate_pkg::div_total(rate_rdata[7:6], 32'(rate_rdata[5:3]), 32'(tx_fine));
      tot_rx = sci_rate_pkg::div_total(rate_rdata[7:6], 32'(rate_rdata[2:0]), 32'(rx_fine));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_seen <= 1'b0;
         txf_d   <= '0;
         rxf_d   <= '0;
         prev_tx <= 0;
         prev_rx <= 0;
      end else begin
         rs_seen <= rate_wr || (tx_fine != txf_d) || (rx_fine != rxf_d);
         txf_d   <= tx_fine;
         rxf_d   <= rx_fine;
         prev_tx <= tot_tx;
         prev_rx <= tot_rx;
      end
   end

   assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rate_wr) |-> rate_rdata == $past(rate_wdata));

   assert_reg_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rate_wr) |-> $stable(rate_rdata));

   assert_tx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tick && tot_tx > 1) |=> !tx_tick);

   assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_tick && tot_rx > 1) |=> !rx_tick);

   assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rs_seen |-> (!tx_tick && !rx_tick));

   assert_tx_unity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rs_seen && prev_tx == 1) |-> tx_tick);

   assert_rx_unity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!rs_seen && prev_rx == 1) |-> rx_tick);

endmodule

bind sci_rate_gen sci_rate_chk #(.FINE_W(FINE_W), .CSEL_W(CSEL_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rate_wr    (rate_wr),
   .rate_wdata (rate_wdata),
   .rate_rdata (rate_rdata),
   .tx_fine    (tx_fine),
   .rx_fine    (rx_fine),
   .tx_tick    (tx_tick),
   .rx_tick    (rx_tick)
);

// File: tb/sci_rate_gen_test.sv
`timescale 1ns/1ps
module sci_rate_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rate_wr = 1'b0;
   logic [7:0] rate_wdata = '0;
   logic [7:0] rate_rdata;
   logic [7:0] tx_fine = '0;
   logic [7:0] rx_fine = '0;
   logic       tx_tick, rx_tick;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   logic [7:0] shadow = '0;
   int         age = 0;
   bit         pending = 0;

   sci_rate_gen uut (
      .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_wdata(rate_wdata),
      .rate_rdata(rate_rdata), .tx_fine(tx_fine), .rx_fine(rx_fine),
      .tx_tick(tx_tick), .rx_tick(rx_tick)
   );

   always #4 clk = ~clk;

   function automatic int bench_presc(input logic [1:0] s);
      int t[4] = '{1, 3, 4, 13};
      return t[s];
   endfunction

   function automatic int bench_period(input logic [7:0] r, input logic [7:0] f, input bit is_tx);
      int sel = is_tx ? int'(r[5:3]) : int'(r[2:0]);
      int d   = (f != 0) ? int'(f) : (2 ** sel);
      return bench_presc(r[7:6]) * d;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         if (n_fails < 25)
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   // One clock: update the model, then compare both ticks (R5, R6, R7, R8, R9).
   task automatic cycle();
      int nt, nr;
      @(posedge clk);
      #2;
      if (pending) begin age = 0; pending = 0; end
      else age++;
      nt = bench_period(shadow, tx_fine, 1'b1);
      nr = bench_period(shadow, rx_fine, 1'b0);
      check("R5 tx_tick", 32'(tx_tick), 32'((age > 0) && (age % nt == 0)));
      check("R5 rx_tick", 32'(rx_tick), 32'((age > 0) && (age % nr == 0)));
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic write_rate(input logic [7:0] v);
      rate_wr = 1'b1; rate_wdata = v; shadow = v; pending = 1;
      cycle();
      rate_wr = 1'b0;
      check("R1 readback", 32'(rate_rdata), 32'(v));
   endtask

   task automatic set_fine(input logic [7:0] t, input logic [7:0] r);
      if (t != tx_fine || r != rx_fine) pending = 1;
      tx_fine = t; rx_fine = r;
   endtask

   task automatic hold_for_config();
      int a = bench_period(shadow, tx_fine, 1'b1);
      int b = bench_period(shadow, rx_fine, 1'b0);
      int m = (a > b) ? a : b;
      run((m > 300) ? 700 : 2 * m + 5);
   endtask

   initial begin
      #(200000 * 8);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      // R2: register reads zero out of reset
      check("R2 reset rdata", 32'(rate_rdata), 32'h0);
      // R2, R9: unity division ticks every cycle
      run(6);

      // R3, R4: largest coarse setting, 13 * 128
      write_rate(8'b11_111_111);
      run(3400);
      // R1, R3, R4: 3*4 transmit, 3*32 receive
      write_rate(8'b01_010_101);
      run(300);
      write_rate(8'b10_000_011);
      run(150);
      // R6, R7: transmit fine only, receive keeps coarse
      set_fine(8'd5, 8'd0);
      run(200);
      // R6, R7: receive fine 255 with prescaler 13
      write_rate(8'b11_000_000);
      set_fine(8'd0, 8'd255);
      run(7000);
      // R8: fine change mid-period restarts both directions
      write_rate(8'b01_011_100);
      run(17);
      set_fine(8'd7, 8'd0);
      run(9);
      // R8: rewrite of the same value mid-period restarts
      write_rate(8'b01_011_100);
      run(60);
      // R9: back to unity division, restart cycle stays low
      set_fine(8'd0, 8'd0);
      write_rate(8'h00);
      run(10);

      for (int s = 0; s < 80; s++) begin
         logic [7:0] v  = 8'($urandom);
         logic [7:0] ft = ($urandom % 2) ? 8'($urandom) : 8'd0;
         logic [7:0] fr = ($urandom % 2) ? 8'($urandom) : 8'd0;
         if ($urandom % 3 == 0) begin
            set_fine(ft, fr);
            run(3);
         end else begin
            set_fine(ft, fr);
            write_rate(v);
         end
         hold_for_config();
      end
      summary();
   end

endmodule